// File: doc/BRIEF.md
# Post-Package Spare Row Repair Manager

This block keeps the spare-row bookkeeping of a memory device with one spare row per bank. A repair request names a bank and a failing row, and the mode enable that is asserted with it marks the request as a temporary (soft) repair or a permanent (hard) repair. Each bank owns one slot, which is empty, soft or hard. A soft repair may be replaced by a later request. A hard repair, once written, is never replaced. Each request returns a response code one cycle after it is accepted.

A lookup port takes every row activate. One cycle later it reports whether the activated row of that bank is remapped to the spare. A soft clear input drops all soft repairs and keeps every hard repair. A status byte reports which repair types this instance supports. The default build has 16 banks; 8 banks suits the narrow-word arrangement.

Top module: `row_spare_mgr`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while `soft_clr` is high. Exactly one cycle after acceptance, `rsp_valid` pulses high for one cycle with `rsp_code`.
- R2: A soft request (only `mode_soft_en` high) to a bank whose slot is empty or soft loads the slot with the request row as a soft repair and responds with code 0.
- R3: A hard request (only `mode_hard_en` high) to a bank whose slot is empty or soft loads the slot with the request row as a hard repair and responds with code 1. An existing soft repair does not need clearing first.
- R4: Any legal request to a bank whose slot is hard responds with code 2 (blocked), and the slot keeps its row and kind.
- R5: A request with both mode enables high, or with neither high, responds with code 3 (error) and changes no slot.
- R6: A request to one bank never changes the slot of any other bank.
- R7: `status` bit 7 equals parameter `HARD_OK` and bit 6 equals `SOFT_OK`; bits 5..0 are zero. A request of a type the instance does not support responds with code 3 and changes nothing.
- R8: `hit` is high in the cycle after an activate (`act_valid`) exactly when the slot of `act_bank` is not empty and holds `act_row`. Otherwise `hit` is low.
- R9: A cycle with `soft_clr` high empties every soft slot and leaves every hard slot unchanged.
- R10: After reset all slots are empty, and `hit` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soft_clr | input | 1 | Empties all soft slots |
| req_valid | input | 1 | Repair request valid |
| req_ready | output | 1 | Request can be accepted |
| mode_soft_en | input | 1 | Soft repair mode enable |
| mode_hard_en | input | 1 | Hard repair mode enable |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Failing row of the request |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | 0 soft done, 1 hard done, 2 blocked, 3 error |
| act_valid | input | 1 | Row activate strobe |
| act_bank | input | BANK_W | Bank being activated |
| act_row | input | ROW_W | Row being activated |
| hit | output | 1 | Activated row is remapped (one cycle later) |
| status | output | 8 | Supported repair types |

## Verification
A slot holding the wrong kind or the wrong row shows at the lookup port on the next activate to that bank, one cycle later. It also shows at the response port on the next request to that bank, because the blocked code depends on the slot kind. The bench therefore follows every request and every soft clear with lookups on the affected bank and on other banks. A lost hard repair, a soft slot that survives a clear, or a write to the wrong bank then appears within two cycles of that probe.

// File: rtl/row_spare_mgr.sv
module row_spare_mgr #(
  parameter int BANKS   = 16,
  parameter int ROW_W   = 17,
  parameter int HARD_OK = 1,
  parameter int SOFT_OK = 1,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              mode_soft_en,
  input  logic              mode_hard_en,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  input  logic              act_valid,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [ROW_W-1:0]  act_row,
  output logic              hit,
  output logic [7:0]        status
);
  typedef enum logic [1:0] {EMPTY = 2'd0, SOFT = 2'd1, HARD = 2'd2} slot_t;

  slot_t            kind  [BANKS];
  logic [ROW_W-1:0] row_q [BANKS];

  wire fire      = req_valid & req_ready;
  wire want_soft = mode_soft_en & ~mode_hard_en & (SOFT_OK != 0);
  wire want_hard = mode_hard_en & ~mode_soft_en & (HARD_OK != 0);
  wire legal     = want_soft | want_hard;
  wire locked    = (kind[req_bank] == HARD);

  assign req_ready = ~soft_clr;
  assign status    = {(HARD_OK != 0), (SOFT_OK != 0), 6'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= 2'd0;
      hit       <= 1'b0;
      for (int b = 0; b < BANKS; b++) kind[b] <= EMPTY;
    end else begin
      rsp_valid <= fire;
      if (fire)
        rsp_code <= !legal ? 2'd3 : locked ? 2'd2 : want_hard ? 2'd1 : 2'd0;
      hit <= act_valid && (kind[act_bank] != EMPTY) && (row_q[act_bank] == act_row);
      for (int b = 0; b < BANKS; b++) begin
        if (soft_clr && kind[b] == SOFT) begin
          kind[b] <= EMPTY;
        end else if (fire && legal && !locked && req_bank == BANK_W'(b)) begin
          kind[b]  <= want_hard ? HARD : SOFT;
          row_q[b] <= req_row;
        end
      end
    end
  end
endmodule

module row_spare_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       mode_soft_en,
  input logic       mode_hard_en,
  input logic       rsp_valid,
  input logic [1:0] rsp_code,
  input logic       act_valid,
  input logic       hit
);
  wire fire = req_valid & req_ready;

  p_rsp_follows_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  p_no_rsp_without_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);
  p_mode_conflict_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_soft_en && mode_hard_en) |=> (rsp_valid && rsp_code == 2'd3));
  p_hit_after_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(act_valid));
endmodule

bind row_spare_mgr row_spare_mgr_chk u_chk (.*);

// File: tb/row_spare_mgr_tb_top.sv
module row_spare_mgr_tb_top;
  localparam int BANKS = 16, ROW_W = 17, BANK_W = 4;

  logic clk = 0, rst_n = 0, soft_clr = 0, req_valid = 0, mode_soft_en = 0, mode_hard_en = 0;
  logic [BANK_W-1:0] req_bank = 0, act_bank = 0;
  logic [ROW_W-1:0] req_row = 0, act_row = 0;
  logic act_valid = 0;
  logic req_ready, rsp_valid, hit;
  logic [1:0] rsp_code;
  logic [7:0] status;

  always #10 clk = ~clk;

  row_spare_mgr dut_i (.*);

  int checks = 0, failures = 0;
  int mk [BANKS];
  int mr [BANKS];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input bit s, input bit h, input int b);
    if (s == h) return 3;
    if (mk[b] == 2) return 2;
    return h ? 1 : 0;
  endfunction

  task automatic do_req(input bit s, input bit h, input int b, input int r, input string tag);
    int e;
    e = exp_code(s, h, b);
    @(negedge clk);
    req_valid = 1; mode_soft_en = s; mode_hard_en = h;
    req_bank = BANK_W'(b); req_row = ROW_W'(r);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    @(negedge clk);
    req_valid = 0; mode_soft_en = 0; mode_hard_en = 0;
    chk(rsp_valid == 1'b1, "R1 rsp_valid", rsp_valid, 1);
    chk(rsp_code == 2'(e), tag, rsp_code, e);
    if (e < 2) begin mk[b] = e + 1; mr[b] = r; end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 pulse", rsp_valid, 0);
  endtask

  task automatic look(input int b, input int r, input string tag);
    bit e;
    e = (mk[b] != 0) && (mr[b] == r);
    @(negedge clk);
    act_valid = 1; act_bank = BANK_W'(b); act_row = ROW_W'(r);
    @(negedge clk);
    act_valid = 0;
    chk(hit == e, tag, hit, e);
  endtask

  task automatic do_clr();
    @(negedge clk);
    soft_clr = 1;
    #1 chk(req_ready == 1'b0, "R1 ready low in clear", req_ready, 0);
    @(negedge clk);
    soft_clr = 0;
    for (int b = 0; b < BANKS; b++) if (mk[b] == 1) mk[b] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < BANKS; b++) begin mk[b] = 0; mr[b] = 0; end
    repeat (3) @(negedge clk);
    chk(hit == 0 && rsp_valid == 0, "R10 reset outputs", {hit, rsp_valid}, 0);
    rst_n = 1;
    look(3, 0, "R10 empty after reset");
    chk(status == 8'hC0, "R7 status", status, 8'hC0);

    do_req(1, 0, 3, 100, "R2 soft load");
    look(3, 100, "R2 soft hit");
    look(3, 101, "R8 miss other row");
    do_req(1, 0, 3, 200, "R2 soft reload");
    look(3, 100, "R2 old row dropped");
    look(3, 200, "R2 new row hit");
    look(4, 200, "R6 other bank empty");
    do_req(0, 1, 3, 300, "R3 hard over soft");
    look(3, 300, "R3 hard hit");
    do_req(1, 0, 3, 400, "R4 soft blocked");
    do_req(0, 1, 3, 500, "R4 hard blocked");
    look(3, 300, "R4 slot kept");
    look(3, 500, "R4 no new row");
    do_req(1, 1, 5, 600, "R5 both enables");
    do_req(0, 0, 5, 600, "R5 no enable");
    look(5, 600, "R5 no change");
    do_req(1, 0, 6, 700, "R6 soft bank 6");
    look(3, 300, "R6 bank 3 untouched");
    do_clr();
    look(6, 700, "R9 soft cleared");
    look(3, 300, "R9 hard kept");

    for (int i = 0; i < 400; i++) begin
      int op, b, r, m;
      op = $urandom_range(0, 19);
      b = $urandom_range(0, BANKS - 1);
      r = $urandom_range(0, 7);
      if (op < 8) begin
        m = $urandom_range(0, 9);
        if (m < 5) do_req(1, 0, b, r, "R2 random soft");
        else if (m < 8) do_req(0, 1, b, r, "R3 random hard");
        else do_req(m[0], m[0], b, r, "R5 random illegal");
      end else if (op < 19) begin
        look(b, (op[0] && mk[b] != 0) ? mr[b] : r, "R8 random lookup");
      end else begin
        do_clr();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule